// File: doc/BRIEF.md
# Reversible-Gate 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns the 8-bit product without a clock. It is built only from models of reversible gates: a two-line copy gate, a three-line controlled-controlled inverter, a three-line half-adder gate and a four-line full-adder gate. Every gate has as many outputs as inputs. The multiplier follows the vertical-and-crosswise scheme. The operands are split into 2-bit halves. Four 2x2 multipliers form the partial products in parallel. Two 4-bit ripple adders then merge the cross terms and the aligned outer terms, and a third 4-bit ripple adder forms the top two product bits.

A signal never feeds two gate inputs directly. Each operand bit that is needed twice first passes through a copy gate whose second input is tied to 0. Every gate output that does not reach the product is collected on a garbage bus, so that the whole network can be observed. The block has no feedback. Operands are plain inputs and results are plain outputs. No handshake applies, because the result is a combinational function of the operands.

Top module: `rvm_vedic4`

## Requirements
- R1: The copy gate maps (a,b) to (a, a xor b). Its four input codes give four distinct outputs.
- R2: The controlled-controlled inverter maps (a,b,c) to (a, b, (a and b) xor c). Its eight input codes give eight distinct outputs.
- R3: The half-adder gate maps (a,b,c) to (a, a xor b, (a and b) xor c). Its eight input codes give eight distinct outputs.
- R4: The full-adder gate maps (a,b,c,d) to (a, b, a xor b xor c, ((a xor b) and c) xor (a and b) xor d). Its sixteen input codes give sixteen distinct outputs.
- R5: The 2x2 stage gives the 4-bit unsigned product of its two 2-bit operands for all 16 pairs. It uses 6 constant inputs and 6 garbage outputs.
- R6: The ripple adder gives the 5-bit value {carry, sum} equal to x + y for all 256 pairs of 4-bit operands. It has 7 garbage outputs.
- R7: prod equals op_a * op_b, unsigned, for all 256 operand pairs.
- R8: prod[1:0] equals the low two bits of op_a[1:0] * op_b[1:0].
- R9: The garbage bus is 49 bits wide. Its top three bits, garb[48:46], are the unused high outputs of the final adder and are always 0.
- R10: In the 2x2 stage, garbage bits [3:0] return the operands as {b[1], a[1], b[0], a[0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | Multiplicand, unsigned |
| op_b | input | 4 | Multiplier, unsigned |
| prod | output | 8 | Unsigned product |
| garb | output | 49 | All gate outputs that do not reach the product, for observation |

## Verification
Every result is combinational, so it is due in the same clock cycle as the operands that produce it, with no register on any path. The bench changes the operands on a falling clock edge. It samples the product, the garbage bus and the outputs of each separately instantiated gate, 2x2 stage and adder 5 ns later, well before the next rising edge. Each gate is swept over its whole input space to check both its mapping and its one-to-one property. The adder and the full multiplier are swept over all 256 operand pairs.

// File: rtl/rvm_pkg.sv
package rvm_pkg;
  parameter int OPW   = 4;
  localparam int HALFW = OPW / 2;
  localparam int PRODW = 2 * OPW;
  localparam int V2W   = 2 * HALFW;
  localparam int V2_GARB = 6;
  localparam int RCA_W = V2W;
  localparam int RCA_GARB = 2 * RCA_W - 1;
  localparam int TOP_GARB = 4 * V2_GARB + 3 * RCA_GARB + 4;
endpackage

// File: rtl/rvm_gates.sv
module rvm_feynman (
  input  logic a,
  input  logic b,
  output logic p,
  output logic q
);
  assign p = a;
  assign q = a ^ b;
  always_comb begin
    p_fey_inverse_r1: assert ((p ^ q) == b) else $error("copy gate not invertible");
  end
endmodule

module rvm_toffoli (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = b;
  assign r = (a & b) ^ c;
  always_comb begin
    p_tof_inverse_r2: assert (((p & q) ^ r) == c) else $error("toffoli not invertible");
  end
endmodule

module rvm_peres (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = (a & b) ^ c;
  always_comb begin
    p_per_inverse_r3: assert (((p & (p ^ q)) ^ r) == c) else $error("half-adder gate not invertible");
  end
endmodule

module rvm_hng (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic p,
  output logic q,
  output logic r,
  output logic s
);
  assign p = a;
  assign q = b;
  assign r = a ^ b ^ c;
  assign s = ((a ^ b) & c) ^ (a & b) ^ d;
  always_comb begin
    p_hng_parity_r4: assert ((p ^ q ^ r) == c) else $error("full-adder gate sum line wrong");
  end
endmodule

// File: rtl/rvm_vedic2.sv
module rvm_vedic2 import rvm_pkg::*; (
  input  logic [HALFW-1:0]   a,
  input  logic [HALFW-1:0]   b,
  output logic [V2W-1:0]     q,
  output logic [V2_GARB-1:0] g
);
  logic a0_1, b0_1, a1_1, b0_2, a0_2, b1_1, a1_2, b1_2;
  logic pp10, pp01, pp11, c1, pp10_g, pp11_g;

  rvm_toffoli u_and00 (.a(a[0]), .b(b[0]), .c(1'b0), .p(a0_1), .q(b0_1), .r(q[0]));
  rvm_toffoli u_and10 (.a(a[1]), .b(b0_1), .c(1'b0), .p(a1_1), .q(b0_2), .r(pp10));
  rvm_toffoli u_and01 (.a(a0_1), .b(b[1]), .c(1'b0), .p(a0_2), .q(b1_1), .r(pp01));
  rvm_toffoli u_and11 (.a(a1_1), .b(b1_1), .c(1'b0), .p(a1_2), .q(b1_2), .r(pp11));
  rvm_peres   u_ha1   (.a(pp10), .b(pp01), .c(1'b0), .p(pp10_g), .q(q[1]), .r(c1));
  rvm_peres   u_ha2   (.a(pp11), .b(c1),   .c(1'b0), .p(pp11_g), .q(q[2]), .r(q[3]));

  assign g = {pp11_g, pp10_g, b1_2, a1_2, b0_2, a0_2};

  always_comb begin
    p_v2_prod_r5: assert ({2'b00, q} == ({2'b00, a} * {2'b00, b})) else $error("2x2 product wrong");
    p_v2_ops_r10: assert (g[3:0] == {b[1], a[1], b[0], a[0]}) else $error("2x2 garbage lost operand");
  end
endmodule

// File: rtl/rvm_rca4.sv
module rvm_rca4 #(
  parameter int W = 4
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [W-1:0]   s,
  output logic           co,
  output logic [2*W-2:0] g
);
  logic [W:1] c;

  rvm_peres u_bit0 (.a(x[0]), .b(y[0]), .c(1'b0), .p(g[0]), .q(s[0]), .r(c[1]));

  for (genvar i = 1; i < W; i++) begin : g_fa
    rvm_hng u_fa (
      .a(x[i]), .b(y[i]), .c(c[i]), .d(1'b0),
      .p(g[2*i-1]), .q(g[2*i]), .r(s[i]), .s(c[i+1])
    );
  end

  assign co = c[W];

  always_comb begin
    p_rca_sum_r6: assert ({co, s} == ({1'b0, x} + {1'b0, y})) else $error("ripple adder sum wrong");
  end
endmodule

// File: rtl/rvm_vedic4.sv
module rvm_vedic4 import rvm_pkg::*; (
  input  logic [OPW-1:0]      op_a,
  input  logic [OPW-1:0]      op_b,
  output logic [PRODW-1:0]    prod,
  output logic [TOP_GARB-1:0] garb
);
  logic [OPW-1:0] a_o, a_c, b_o, b_c;
  logic [V2W-1:0]     qp [4];
  logic [V2_GARB-1:0] qg [4];

  // copy every operand bit once: original and copy each feed one quadrant
  for (genvar i = 0; i < OPW; i++) begin : g_copy
    rvm_feynman u_cpa (.a(op_a[i]), .b(1'b0), .p(a_o[i]), .q(a_c[i]));
    rvm_feynman u_cpb (.a(op_b[i]), .b(1'b0), .p(b_o[i]), .q(b_c[i]));
  end

  // quadrant k: bit0 selects the half of op_a, bit1 the half of op_b
  for (genvar k = 0; k < 4; k++) begin : g_quad
    localparam int AI = k % 2;
    localparam int BI = k / 2;
    logic [HALFW-1:0] xa, xb;
    if (BI == 0) begin : g_ao
      assign xa = a_o[AI*HALFW +: HALFW];
    end else begin : g_ac
      assign xa = a_c[AI*HALFW +: HALFW];
    end
    if (AI == 0) begin : g_bo
      assign xb = b_o[BI*HALFW +: HALFW];
    end else begin : g_bc
      assign xb = b_c[BI*HALFW +: HALFW];
    end
    rvm_vedic2 u_v2 (.a(xa), .b(xb), .q(qp[k]), .g(qg[k]));
  end

  logic [RCA_W-1:0]    s1, s2, s3;
  logic                c1, c2, c3;
  logic [RCA_GARB-1:0] g1, g2, g3;
  logic                cc_g, cc_s, cc_c;

  rvm_rca4 #(.W(RCA_W)) u_l2a (.x(qp[1]), .y(qp[2]), .s(s1), .co(c1), .g(g1));
  rvm_rca4 #(.W(RCA_W)) u_l2b (
    .x(s1), .y({qp[3][HALFW-1:0], qp[0][V2W-1:HALFW]}), .s(s2), .co(c2), .g(g2)
  );
  rvm_peres u_cmerge (.a(c1), .b(c2), .c(1'b0), .p(cc_g), .q(cc_s), .r(cc_c));
  rvm_rca4 #(.W(RCA_W)) u_l3 (
    .x({{(RCA_W-HALFW){1'b0}}, qp[3][V2W-1:HALFW]}),
    .y({{(RCA_W-2){1'b0}}, cc_c, cc_s}),
    .s(s3), .co(c3), .g(g3)
  );

  assign prod = {s3[HALFW-1:0], s2, qp[0][HALFW-1:0]};
  assign garb = {s3[RCA_W-1:HALFW], c3, cc_g, g3, g2, g1, qg[3], qg[2], qg[1], qg[0]};

  always_comb begin
    p_top_prod_r7: assert ({8'd0, prod} == ({12'd0, op_a} * {12'd0, op_b})) else $error("product wrong");
    p_spare_zero_r9: assert (garb[TOP_GARB-1 -: 3] == 3'b000) else $error("final adder overflowed");
  end
endmodule

// File: tb/rvm_vedic4_tb.sv
module rvm_vedic4_tb;
  import rvm_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [3:0] op_a = '0, op_b = '0;
  logic [7:0] prod;
  logic [TOP_GARB-1:0] garb;
  rvm_vedic4 u_dut (.op_a(op_a), .op_b(op_b), .prod(prod), .garb(garb));

  logic ga = 0, gb = 0, gc = 0, gd = 0;
  logic fp, fq, tp, tq, tr, pp, pq, pr, hp, hq, hr, hs;
  rvm_feynman u_fey (.a(ga), .b(gb), .p(fp), .q(fq));
  rvm_toffoli u_tof (.a(ga), .b(gb), .c(gc), .p(tp), .q(tq), .r(tr));
  rvm_peres   u_per (.a(ga), .b(gb), .c(gc), .p(pp), .q(pq), .r(pr));
  rvm_hng     u_hng (.a(ga), .b(gb), .c(gc), .d(gd), .p(hp), .q(hq), .r(hr), .s(hs));

  logic [1:0] va = 0, vb = 0;
  logic [3:0] vq;
  logic [5:0] vg;
  rvm_vedic2 u_v2 (.a(va), .b(vb), .q(vq), .g(vg));

  logic [3:0] rx = 0, ry = 0, rs;
  logic rco;
  logic [6:0] rg;
  rvm_rca4 #(.W(4)) u_rca (.x(rx), .y(ry), .s(rs), .co(rco), .g(rg));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic sample();
    #5;
  endtask

  task automatic test_reset();
    settle(); op_a = 0; op_b = 0; sample();
    chk("R7 reset product", prod, 0);
    chk("R9 reset spare", garb[TOP_GARB-1 -: 3], 0);
  endtask

  task automatic test_feynman();
    bit seen [4];
    for (int i = 0; i < 4; i++) seen[i] = 0;
    for (int v = 0; v < 4; v++) begin
      settle(); {ga, gb} = v[1:0]; sample();
      chk("R1 copy map", {fp, fq}, {ga, ga ^ gb});
      chk("R1 copy distinct", seen[{fp, fq}], 0);
      seen[{fp, fq}] = 1;
    end
  endtask

  task automatic test_toffoli();
    bit seen [8];
    for (int i = 0; i < 8; i++) seen[i] = 0;
    for (int v = 0; v < 8; v++) begin
      settle(); {ga, gb, gc} = v[2:0]; sample();
      chk("R2 ccnot map", {tp, tq, tr}, {ga, gb, (ga & gb) ^ gc});
      chk("R2 ccnot distinct", seen[{tp, tq, tr}], 0);
      seen[{tp, tq, tr}] = 1;
    end
  endtask

  task automatic test_peres();
    bit seen [8];
    for (int i = 0; i < 8; i++) seen[i] = 0;
    for (int v = 0; v < 8; v++) begin
      settle(); {ga, gb, gc} = v[2:0]; sample();
      chk("R3 half-adder gate map", {pp, pq, pr}, {ga, ga ^ gb, (ga & gb) ^ gc});
      chk("R3 half-adder gate distinct", seen[{pp, pq, pr}], 0);
      seen[{pp, pq, pr}] = 1;
    end
  endtask

  task automatic test_hng();
    bit seen [16];
    for (int i = 0; i < 16; i++) seen[i] = 0;
    for (int v = 0; v < 16; v++) begin
      settle(); {ga, gb, gc, gd} = v[3:0]; sample();
      chk("R4 full-adder gate map", {hp, hq, hr, hs},
          {ga, gb, ga ^ gb ^ gc, ((ga ^ gb) & gc) ^ (ga & gb) ^ gd});
      chk("R4 full-adder gate distinct", seen[{hp, hq, hr, hs}], 0);
      seen[{hp, hq, hr, hs}] = 1;
    end
  endtask

  task automatic test_vedic2();
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 4; y++) begin
        settle(); va = x[1:0]; vb = y[1:0]; sample();
        chk("R5 2x2 product", vq, x * y);
        chk("R10 2x2 operand garbage", vg[3:0], {vb[1], va[1], vb[0], va[0]});
      end
  endtask

  task automatic test_rca();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        settle(); rx = x[3:0]; ry = y[3:0]; sample();
        chk("R6 adder sum", {rco, rs}, x + y);
      end
  endtask

  task automatic test_mult_all();
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        settle(); op_a = x[3:0]; op_b = y[3:0]; sample();
        chk("R7 product", prod, x * y);
        chk("R8 low bits", prod[1:0], ((x % 4) * (y % 4)) % 4);
        chk("R9 spare zero", garb[48:46], 0);
      end
  endtask

  task automatic test_corners();
    settle(); op_a = 4'hF; op_b = 4'hF; sample();
    chk("R7 max operands", prod, 8'd225);
    settle(); op_a = 4'hA; op_b = 4'h5; sample();
    chk("R7 alternating bits", prod, 8'd50);
    settle(); op_a = 4'h1; op_b = 4'hD; sample();
    chk("R7 unit operand", prod, 8'd13);
    chk("R9 width", $bits(garb), 49);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_feynman();
    test_toffoli();
    test_peres();
    test_hng();
    test_vedic2();
    test_rca();
    test_mult_all();
    test_corners();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule